// File: doc/BRIEF.md
# Serial Transmit Channel with CTS Gating and Automatic RTS Release

This block is the transmit half of an asynchronous serial port. A host bus programs two mode registers that share one address: an access pointer picks which one is reached. The host then writes characters into a one-entry holding register. Each character moves into a shift register and goes out on `txd` as one start bit, eight data bits with the least significant bit first, and one or two stop bits. The bit rate comes from a one-cycle `baud_tick` strobe, where one strobe marks one bit time.

Two flow-control features can be turned on in the second mode register. With CTS gating on, the transmitter looks at the synchronized clear-to-send input only when it could begin a new character. If clear-to-send is negated at that moment, the line stays high and the character waits in the holding register. A character that has already started is never cut short. With automatic RTS release on, the host raises RTS through an output-control write. The block then drops RTS one bit time after the last stop bit, once nothing is left to send.

Top module: `uart_tx_flow`

## Requirements
- R1: A character leaves `txd` as one low start bit, then data bits 0 through 7, then high stop bits. The line idles high. `txd` changes only in the clock cycle after a cycle in which `baud_tick` is high, and each bit lasts one tick interval.
- R2: Mode B bit 0 selects the stop-bit count: 0 gives one stop bit and 1 gives two stop bits.
- R3: A character written to the holding register (address 2) while another is being sent starts on the tick that ends the last stop bit of the previous character. No idle bit comes between them.
- R4: When mode B bit 4 is set and `cts_n` (active low, passed through two flip-flops) is high at a character boundary, `txd` stays high and the holding register stays full (status bit 0 at address 2). The character starts on the first tick after `cts_n` has been low through the synchronizer.
- R5: A change of `cts_n` after the start bit has begun does not alter or stop the character in flight.
- R6: When mode B bit 4 is clear, `cts_n` has no effect on transmission.
- R7: When mode B bit 5 is set and mode A bit 7 is clear, the RTS level clears one tick after the tick that ends the last stop bit, provided the holding register is empty at that point.
- R8: When mode B bit 5 is clear, or mode A bit 7 and mode B bit 5 are both set, the transmitter leaves the RTS level unchanged.
- R9: Writing address 3 with bit 0 set raises the RTS level, and writing it with bit 1 set clears it. Bit 0 of a read at address 3 returns the level. `rts_n` is its inverse.
- R10: Address 0 reaches mode A when the pointer is at A and mode B otherwise. Any read or write of mode A moves the pointer to B. Accesses to mode B leave the pointer where it is. Writing address 1 with bit 0 set returns the pointer to A.
- R11: After reset the pointer is at A, both mode registers read 0, `txd` is high, `rts_n` is high and status at address 2 reads 0 (bit 1 busy, bit 0 holding full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from `addr` |
| baud_tick | input | 1 | One pulse per bit time |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| txd | output | 1 | Serial data out |
| rts_n | output | 1 | Ready-to-send, active low |

## Verification
Every serial result appears one clock after the tick that causes it. The bench raises `baud_tick` for exactly one cycle and reads `txd`, `rts_n` and the status bits at the falling edge that follows. Register reads are combinational, so they are sampled before the next rising edge. A pointer move takes effect at that edge and is checked on the following access. A change on `cts_n` needs two clocks to pass the synchronizer, so the bench waits three clocks before the tick that should see it. The automatic RTS release is checked on two separate ticks: the tick that ends the stop bit, where RTS must still be asserted, and the next tick, where it must have dropped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic {PTR_A = 1'b0, PTR_B = 1'b1} mode_ptr_e;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;

    localparam int ADDR_MODE = 0;
    localparam int ADDR_CMD  = 1;
    localparam int ADDR_DATA = 2;
    localparam int ADDR_OUT  = 3;

    localparam int MA_RX_RTS   = 7;
    localparam int MB_TX_RTS   = 5;
    localparam int MB_TX_CTS   = 4;
    localparam int MB_STOP2    = 0;
    localparam int CMD_PTR_RST = 0;
    localparam int OUT_SET     = 0;
    localparam int OUT_CLR     = 1;
endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_async,
    output logic cts_ok
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], cts_n_async};
        end else begin : g_single
            always_comb sync_d = cts_n_async;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign cts_ok = ~sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              hold_full,
    input  logic              busy,
    input  logic              rts_release,
    output logic              hold_wr,
    output logic              cts_en,
    output logic              rts_auto_en,
    output logic              two_stop,
    output logic              rts_level,
    output mode_ptr_e         ptr
);
    typedef struct packed {
        logic [DATA_W-1:0] mode_a;
        logic [DATA_W-1:0] mode_b;
        mode_ptr_e         ptr;
        logic              rts;
    } regs_t;

    regs_t r_d, r_q;

    logic sel_mode, sel_cmd, sel_data, sel_out;
    assign sel_mode = (addr == ADDR_W'(ADDR_MODE));
    assign sel_cmd  = (addr == ADDR_W'(ADDR_CMD));
    assign sel_data = (addr == ADDR_W'(ADDR_DATA));
    assign sel_out  = (addr == ADDR_W'(ADDR_OUT));

    assign rts_auto_en = r_q.mode_b[MB_TX_RTS] & ~r_q.mode_a[MA_RX_RTS];
    assign cts_en      = r_q.mode_b[MB_TX_CTS];
    assign two_stop    = r_q.mode_b[MB_STOP2];
    assign rts_level   = r_q.rts;
    assign ptr         = r_q.ptr;
    assign hold_wr     = wr_en && sel_data;

    always_comb begin
        r_d = r_q;
        if (rts_release && rts_auto_en) r_d.rts = 1'b0;
        if (wr_en) begin
            if (sel_mode) begin
                if (r_q.ptr == PTR_A) begin
                    r_d.mode_a = wdata;
                    r_d.ptr    = PTR_B;
                end else begin
                    r_d.mode_b = wdata;
                end
            end else if (sel_cmd) begin
                if (wdata[CMD_PTR_RST]) r_d.ptr = PTR_A;
            end else if (sel_out) begin
                if (wdata[OUT_SET]) r_d.rts = 1'b1;
                if (wdata[OUT_CLR]) r_d.rts = 1'b0;
            end
        end else if (rd_en && sel_mode && r_q.ptr == PTR_A) begin
            r_d.ptr = PTR_B;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_mode)      rdata = (r_q.ptr == PTR_A) ? r_q.mode_a : r_q.mode_b;
        else if (sel_data) rdata = {{(DATA_W-2){1'b0}}, busy, hold_full};
        else if (sel_out)  rdata = {{(DATA_W-1){1'b0}}, r_q.rts};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode_a: '0, mode_b: '0, ptr: PTR_A, rts: 1'b0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 hold_wr,
    input  logic [DATA_BITS-1:0] hold_data,
    input  logic                 cts_en,
    input  logic                 cts_ok,
    input  logic                 two_stop,
    output logic                 txd,
    output logic                 hold_full,
    output logic                 busy,
    output logic                 load,
    output logic                 rts_release
);
    localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

    typedef struct packed {
        tx_state_e            st;
        logic [DATA_BITS-1:0] hold;
        logic                 full;
        logic [DATA_BITS-1:0] shift;
        logic [CNT_W-1:0]     cnt;
        logic                 stop_cnt;
        logic                 txd;
        logic                 drain;
    } tx_t;

    tx_t s_d, s_q;
    logic go, boundary;

    assign go          = s_q.full && (!cts_en || cts_ok);
    assign boundary    = (s_q.st == TX_IDLE) ||
                         (s_q.st == TX_STOP && s_q.stop_cnt == two_stop);
    assign load        = baud_tick && boundary && go;
    assign rts_release = baud_tick && s_q.st == TX_IDLE && s_q.drain && !s_q.full;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.shift = s_q.hold;
            s_d.full  = 1'b0;
            s_d.st    = TX_START;
            s_d.txd   = 1'b0;
            s_d.drain = 1'b0;
        end else if (baud_tick) begin
            unique case (s_q.st)
                TX_IDLE: if (rts_release) s_d.drain = 1'b0;
                TX_START: begin
                    s_d.txd   = s_q.shift[0];
                    s_d.shift = s_q.shift >> 1;
                    s_d.cnt   = '0;
                    s_d.st    = TX_DATA;
                end
                TX_DATA: begin
                    if (s_q.cnt == LAST_BIT) begin
                        s_d.txd      = 1'b1;
                        s_d.st       = TX_STOP;
                        s_d.stop_cnt = 1'b0;
                    end else begin
                        s_d.txd   = s_q.shift[0];
                        s_d.shift = s_q.shift >> 1;
                        s_d.cnt   = s_q.cnt + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (boundary) begin
                        s_d.st    = TX_IDLE;
                        s_d.drain = 1'b1;
                    end else begin
                        s_d.stop_cnt = 1'b1;
                    end
                end
                default: s_d.st = TX_IDLE;
            endcase
        end
        if (hold_wr) begin
            s_d.hold  = hold_data;
            s_d.full  = 1'b1;
            s_d.drain = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: TX_IDLE, hold: '0, full: 1'b0, shift: '0, cnt: '0,
                             stop_cnt: 1'b0, txd: 1'b1, drain: 1'b0};
        else        s_q <= s_d;
    end

    assign txd       = s_q.txd;
    assign hold_full = s_q.full;
    assign busy      = (s_q.st != TX_IDLE);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              baud_tick,
    input  logic              cts_n,
    output logic              txd,
    output logic              rts_n
);
    logic      cts_ok, hold_wr, cts_en, rts_auto_en, two_stop, rts_level;
    logic      hold_full, busy, load, rts_release;
    mode_ptr_e ptr;

    uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cts_n_async(cts_n), .cts_ok(cts_ok)
    );

    uart_tx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hold_full(hold_full), .busy(busy),
        .rts_release(rts_release), .hold_wr(hold_wr), .cts_en(cts_en),
        .rts_auto_en(rts_auto_en), .two_stop(two_stop), .rts_level(rts_level),
        .ptr(ptr)
    );

    uart_tx_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .hold_wr(hold_wr),
        .hold_data(wdata[DATA_BITS-1:0]), .cts_en(cts_en), .cts_ok(cts_ok),
        .two_stop(two_stop), .txd(txd), .hold_full(hold_full), .busy(busy),
        .load(load), .rts_release(rts_release)
    );

    assign rts_n = ~rts_level;
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk
    import uart_tx_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              txd,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rts_level,
    input logic              rts_auto_en,
    input logic              load,
    input logic              cts_en,
    input logic              cts_ok,
    input mode_ptr_e         ptr
);
    logic host_clr, host_out, host_ptr_rst;
    assign host_out     = wr_en && addr == ADDR_W'(ADDR_OUT);
    assign host_clr     = host_out && wdata[OUT_CLR];
    assign host_ptr_rst = wr_en && addr == ADDR_W'(ADDR_CMD) && wdata[CMD_PTR_RST];

    assert_txd_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    assert_cts_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cts_en) |-> cts_ok);

    assert_rts_auto_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_level) |-> ($past(host_clr) || $past(baud_tick && rts_auto_en)));

    assert_rts_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_auto_en && !host_out) |=> !$fell(rts_level));

    assert_ptr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == PTR_B && !host_ptr_rst) |=> ptr == PTR_B);
endmodule

bind uart_tx_flow uart_tx_flow_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .txd(txd), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rts_level(rts_level), .rts_auto_en(rts_auto_en),
    .load(load), .cts_en(cts_en), .cts_ok(cts_ok), .ptr(ptr)
);

// File: tb/uart_tx_flow_tb.sv
`timescale 1ns/1ps
module uart_tx_flow_tb;
    import uart_tx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, baud_tick = 1'b0, cts_n = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd, rts_n;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    uart_tx_flow u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .baud_tick(baud_tick), .cts_n(cts_n),
        .txd(txd), .rts_n(rts_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 2'(a);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); baud_tick = 1'b1;
        @(negedge clk); baud_tick = 1'b0;
    endtask

    task automatic wait_sync();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input int j);
        if (j == 0) return 1'b0;
        if (j <= 8) return b[j-1];
        return 1'b1;
    endfunction

    task automatic set_mode(input logic [7:0] ma, input logic [7:0] mb);
        wr(ADDR_CMD, 8'h01);
        wr(ADDR_MODE, ma);
        wr(ADDR_MODE, mb);
    endtask

    task automatic frame_ticks(input logic [7:0] b, input int from, input int to, input string tag);
        for (int j = from; j <= to; j++) begin
            tick();
            chk(tag, txd, exp_bit(b, j));
        end
    endtask

    task automatic end_tick(input string tag);
        logic [7:0] st;
        tick();
        chk(tag, txd, 1'b1);
        rd(ADDR_DATA, st);
        chk(tag, st, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 txd", txd, 1'b1);
        chk("R11 rts_n", rts_n, 1'b1);
        rd(ADDR_DATA, v); chk("R11 status", v, 8'h00);
        rd(ADDR_MODE, v); chk("R11 mode A", v, 8'h00);
        rd(ADDR_MODE, v); chk("R11 mode B", v, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        set_mode(8'h15, 8'hC2);
        rd(ADDR_MODE, v); chk("R10 B read", v, 8'hC2);
        rd(ADDR_MODE, v); chk("R10 B sticky", v, 8'hC2);
        wr(ADDR_CMD, 8'h01);
        rd(ADDR_MODE, v); chk("R10 A after reset cmd", v, 8'h15);
        rd(ADDR_MODE, v); chk("R10 B after A read", v, 8'hC2);
        set_mode(8'h00, 8'h00);
    endtask

    task automatic t_frame(input logic [7:0] b, input int stops, input string tag);
        set_mode(8'h00, stops == 2 ? 8'h01 : 8'h00);
        wr(ADDR_DATA, b);
        frame_ticks(b, 0, 8 + stops, tag);
        end_tick(tag);
    endtask

    task automatic t_pair(input logic [7:0] b1, input logic [7:0] b2, input int stops);
        logic [7:0] st;
        int len;
        len = 9 + stops;
        set_mode(8'h00, stops == 2 ? 8'h01 : 8'h00);
        wr(ADDR_DATA, b1);
        tick();
        chk("R3 first start", txd, 1'b0);
        wr(ADDR_DATA, b2);
        rd(ADDR_DATA, st); chk("R3 busy and full", st, 8'h03);
        for (int k = 1; k < 2 * len; k++) begin
            tick();
            chk(stops == 2 ? "R3 R2 two stops" : "R3 R2 one stop", txd,
                exp_bit(k < len ? b1 : b2, k % len));
        end
        end_tick("R3 idle after pair");
    endtask

    task automatic t_cts_block();
        logic [7:0] st;
        set_mode(8'h00, 8'h10);
        cts_n = 1'b1; wait_sync();
        wr(ADDR_DATA, 8'h96);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 held high", txd, 1'b1);
        end
        rd(ADDR_DATA, st); chk("R4 still pending", st, 8'h01);
        cts_n = 1'b0; wait_sync();
        frame_ticks(8'h96, 0, 9, "R4 released frame");
        end_tick("R4 end");
    endtask

    task automatic t_cts_midchar();
        set_mode(8'h00, 8'h10);
        wr(ADDR_DATA, 8'h5B);
        frame_ticks(8'h5B, 0, 3, "R5 before change");
        cts_n = 1'b1;
        frame_ticks(8'h5B, 4, 9, "R5 after change");
        end_tick("R5 end");
        cts_n = 1'b0; wait_sync();
    endtask

    task automatic t_cts_off();
        set_mode(8'h00, 8'h00);
        cts_n = 1'b1; wait_sync();
        wr(ADDR_DATA, 8'hE1);
        frame_ticks(8'hE1, 0, 9, "R6 ignored cts");
        end_tick("R6 end");
        cts_n = 1'b0; wait_sync();
    endtask

    task automatic t_rts_auto();
        logic [7:0] v;
        set_mode(8'h00, 8'h20);
        wr(ADDR_OUT, 8'h01);
        chk("R9 rts_n after set", rts_n, 1'b0);
        rd(ADDR_OUT, v); chk("R9 readback set", v, 8'h01);
        wr(ADDR_DATA, 8'h33);
        frame_ticks(8'h33, 0, 9, "R7 frame");
        tick();
        chk("R7 still asserted at stop end", rts_n, 1'b0);
        tick();
        chk("R7 released one bit later", rts_n, 1'b1);
        rd(ADDR_OUT, v); chk("R7 readback cleared", v, 8'h00);
    endtask

    task automatic t_rts_kept(input logic [7:0] ma, input logic [7:0] mb, input string tag);
        set_mode(ma, mb);
        wr(ADDR_OUT, 8'h01);
        wr(ADDR_DATA, 8'h0F);
        frame_ticks(8'h0F, 0, 9, tag);
        repeat (3) tick();
        chk(tag, rts_n, 1'b0);
    endtask

    task automatic t_rts_clear();
        logic [7:0] v;
        wr(ADDR_OUT, 8'h02);
        chk("R9 rts_n after clear", rts_n, 1'b1);
        rd(ADDR_OUT, v); chk("R9 readback clear", v, 8'h00);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_frame(8'hA5, 1, "R1 frame A5");
        t_frame(8'h3C, 2, "R2 frame 3C two stops");
        t_pair(8'h81, 8'h7E, 1);
        t_pair(8'h4D, 8'hB2, 2);
        t_cts_block();
        t_cts_midchar();
        t_cts_off();
        t_rts_auto();
        t_rts_kept(8'h00, 8'h00, "R8 auto off");
        t_rts_kept(8'h80, 8'h20, "R8 both enables conflict");
        t_rts_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule